// File: doc/BRIEF.md
# Indexed SMBus Configuration Register Target

This block is a two-wire bus target that gives a host access to a small bank of eight-bit configuration registers for a clock buffer. The host names a starting register index, and on writes a byte count, then moves a run of consecutive registers in one transfer. The index pointer steps after every data byte and wraps from the last register back to register 0. Reads are entered with a repeated start. The target answers first with a length byte, which it takes from a writable register in the bank, and then sends registers from the starting index onward until the host declines a byte.

SCL and SDA are sampled in the system clock domain through a two-flop synchronizer. The target only ever pulls SDA low; the line returns high through the bus pull-up. The register contents drive the buffer's mode controls, its per-output enables and its per-output stop selection. Two registers are read-only identification: one combines a revision nibble from an input port with a fixed vendor nibble, the other holds a fixed device code.

Top module: `idx_smbus_target`

## Requirements
- R1: After reset, `mode_o` is 0x07, `out_en_o` is 0xFF, `stop_sel_o` is 0x00 and `sda_pull_o` is 0.
- R2: The target acknowledges the address bytes 0xDC (write) and 0xDD (read) by pulling SDA low during the ninth clock. It changes its SDA drive only while SCL is low. It acknowledges no other address, and after such an address it ignores every byte until the next start.
- R3: A write transfer is start, 0xDC, index N, count X, then X data bytes that go to registers N, N+1, and so on. Every one of these bytes is acknowledged. Bits travel MSB first.
- R4: A data byte that arrives after X data bytes have been taken is not acknowledged and writes nothing.
- R5: A read transfer is start, 0xDC, index N, repeated start, 0xDD. The target then sends the length byte, followed by registers N, N+1, and so on, MSB first.
- R6: The target sends the next register each time the host acknowledges. When the host leaves the acknowledge bit high, the transfer ends and SDA stays released.
- R7: Register 6 holds the readback length. It resets to 7, it is writable, and its value is the first byte of every read.
- R8: Register 4 reads as {`rev_id_i`, 4'h1} and register 5 reads as 0x81. Writes to either register are acknowledged and have no effect.
- R9: Register 0 appears on `mode_o`. Its bits 7, 6, 2, 1 and 0 are writable. Its bits 5 to 3 always read 0 and ignore writes.
- R10: Register 1 drives `out_en_o` and register 2 drives `stop_sel_o`. Register 3 is a plain read/write spare. The pointer wraps from register 6 to register 0 on both writes and reads. A starting index is reduced modulo the register count, so index 9 selects register 2.
- R11: A start or stop in the middle of a byte abandons that byte and writes nothing. A start then begins a new address phase.
- R12: A written value appears on its output exactly three system clock cycles after SCL rises at the pin for the eighth bit of the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| rev_id_i | input | 4 | Revision nibble shown in register 4 |
| mode_o | output | 8 | Register 0: mode controls |
| out_en_o | output | 8 | Register 1: per-output enables |
| stop_sel_o | output | 8 | Register 2: per-output stoppable selects |

## Verification
The bench builds the block with its defaults: seven registers, addresses 0xDC and 0xDD, and a four-cycle quarter bit on the bus. With seven registers, a non-power-of-two count, both the wrap from register 6 to register 0 and the modulo reduction of a starting index of 9 occur within a few bytes. Because the quarter bit is longer than the three-cycle synchronizer path, the cycle at which each write reaches the outputs can be predicted exactly and compared on every clock. The same timing lets the bench break bytes off part-way with a start or a stop.

// File: rtl/ist_pkg.sv
package ist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_DONE,
        ST_ACK,
        ST_TX,
        ST_TX_END,
        ST_TX_ACK,
        ST_TX_NEXT
    } ist_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_INDEX,
        K_COUNT,
        K_DATA
    } ist_kind_e;

    // Register roles inside the bank
    localparam int ROLE_MODE  = 0;
    localparam int ROLE_OE    = 1;
    localparam int ROLE_STOP  = 2;
    localparam int ROLE_SPARE = 3;
    localparam int ROLE_ID    = 4;
    localparam int ROLE_DEV   = 5;
    localparam int ROLE_RDLEN = 6;
    localparam int ROLE_COUNT = 7;

endpackage

// File: rtl/ist_line_sync.sv
module ist_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;   // bit 0: clock line, bit 1: data line

    typedef struct packed {
        logic [LINES-1:0] meta;
        logic [LINES-1:0] sync;
        logic [LINES-1:0] prev;
    } pipe_t;

    pipe_t q, d;
    logic [LINES-1:0] rise, fall;

    always_comb begin
        d      = q;
        d.meta = {sda_i, scl_i};
        d.sync = q.meta;
        d.prev = q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{meta: '1, sync: '1, prev: '1};
        else        q <= d;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_edge
        assign rise[g] = q.sync[g] & ~q.prev[g];
        assign fall[g] = ~q.sync[g] & q.prev[g];
    end

    assign scl_rise  = rise[0];
    assign scl_fall  = fall[0];
    assign scl_lvl   = q.sync[0];
    assign sda_lvl   = q.sync[1];
    // Data line moves while the clock line stays high on both samples
    assign start_det = q.sync[0] & q.prev[0] & fall[1];
    assign stop_det  = q.sync[0] & q.prev[0] & rise[1];

endmodule

// File: rtl/ist_reg_bank.sv
module ist_reg_bank #(
    parameter int          NUM_REGS    = 7,
    parameter int          IDX_W       = 3,
    parameter logic [7:0]  MODE_RESET  = 8'h07,
    parameter logic [7:0]  MODE_WMASK  = 8'hC7,
    parameter logic [7:0]  RDLEN_RESET = 8'h07,
    parameter logic [3:0]  VENDOR_CODE = 4'h1,
    parameter logic [7:0]  DEV_CODE    = 8'h81
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [3:0]       rev_id_i,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [7:0]       rd_len,
    output logic [7:0]       mode_o,
    output logic [7:0]       out_en_o,
    output logic [7:0]       stop_sel_o
);
    import ist_pkg::*;

    typedef struct packed {
        logic [NUM_REGS-1:0][7:0] regs;
    } bank_t;

    function automatic bank_t reset_image();
        bank_t b;
        for (int i = 0; i < NUM_REGS; i++) begin
            case (i)
                ROLE_MODE:  b.regs[i] = MODE_RESET & MODE_WMASK;
                ROLE_OE:    b.regs[i] = 8'hFF;
                ROLE_ID:    b.regs[i] = {4'h0, VENDOR_CODE};
                ROLE_DEV:   b.regs[i] = DEV_CODE;
                ROLE_RDLEN: b.regs[i] = RDLEN_RESET;
                default:    b.regs[i] = 8'h00;
            endcase
        end
        return b;
    endfunction

    localparam bank_t BANK_RESET = reset_image();

    bank_t q, d;
    logic  is_ro;

    always_comb begin
        d = q;
        // Identification slots are refreshed every cycle and never written
        d.regs[ROLE_ID]  = {rev_id_i, VENDOR_CODE};
        d.regs[ROLE_DEV] = DEV_CODE;
        is_ro = (wr_idx == IDX_W'(ROLE_ID)) || (wr_idx == IDX_W'(ROLE_DEV));
        if (wr_en && !is_ro) begin
            if (wr_idx == IDX_W'(ROLE_MODE)) d.regs[ROLE_MODE] = wr_data & MODE_WMASK;
            else                             d.regs[wr_idx]    = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= BANK_RESET;
        else        q <= d;
    end

    assign rd_data    = q.regs[rd_idx];
    assign rd_len     = q.regs[ROLE_RDLEN];
    assign mode_o     = q.regs[ROLE_MODE];
    assign out_en_o   = q.regs[ROLE_OE];
    assign stop_sel_o = q.regs[ROLE_STOP];

    // R9: reserved mode bits never show up on the output
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o & ~MODE_WMASK) == 8'h00);

    // R8: a write aimed at the device-code slot leaves the code in place
    p_dev_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(ROLE_DEV)) |=> q.regs[ROLE_DEV] == DEV_CODE);

    // R8: a write aimed at the revision slot still shows the revision input
    p_id_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(ROLE_ID)) |=> q.regs[ROLE_ID] == {$past(rev_id_i), VENDOR_CODE});

endmodule

// File: rtl/ist_proto_fsm.sv
module ist_proto_fsm #(
    parameter int         NUM_REGS = 7,
    parameter int         IDX_W    = 3,
    parameter logic [7:0] WR_ADDR  = 8'hDC,
    parameter logic [7:0] RD_ADDR  = 8'hDD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       rd_len,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sda_pull
);
    import ist_pkg::*;

    typedef struct packed {
        ist_state_e       state;
        ist_kind_e        kind;
        logic [2:0]       bitcnt;
        logic [7:0]       shreg;
        logic             ack;
        logic             go_tx;
        logic [IDX_W-1:0] ptr;
        logic [7:0]       left;
        logic             drive;
    } fsm_t;

    fsm_t q, d;
    logic [7:0]       rx_byte;
    logic [IDX_W-1:0] next_ptr;

    assign rx_byte  = {q.shreg[6:0], sda_lvl};
    assign next_ptr = (q.ptr == IDX_W'(NUM_REGS - 1)) ? '0 : q.ptr + IDX_W'(1);

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_idx  = q.ptr;
        wr_data = rx_byte;
        if (stop_det) begin
            d.state = ST_IDLE;
            d.drive = 1'b0;
        end else if (start_det) begin
            d.state  = ST_RX;
            d.kind   = K_ADDR;
            d.bitcnt = '0;
            d.drive  = 1'b0;
        end else begin
            unique case (q.state)
                ST_IDLE: ;
                ST_RX: if (scl_rise) begin
                    d.shreg  = rx_byte;
                    d.bitcnt = q.bitcnt + 3'd1;
                    if (q.bitcnt == 3'd7) begin
                        d.state = ST_RX_DONE;
                        d.ack   = 1'b1;
                        d.go_tx = 1'b0;
                        unique case (q.kind)
                            K_ADDR: begin
                                if (rx_byte == WR_ADDR)      d.kind  = K_INDEX;
                                else if (rx_byte == RD_ADDR) d.go_tx = 1'b1;
                                else                         d.ack   = 1'b0;
                            end
                            K_INDEX: begin
                                d.ptr  = IDX_W'(32'(rx_byte) % NUM_REGS);
                                d.kind = K_COUNT;
                            end
                            K_COUNT: begin
                                d.left = rx_byte;
                                d.kind = K_DATA;
                            end
                            K_DATA: begin
                                if (q.left != 8'd0) begin
                                    wr_en  = 1'b1;
                                    d.left = q.left - 8'd1;
                                    d.ptr  = next_ptr;
                                end else begin
                                    d.ack = 1'b0;
                                end
                            end
                        endcase
                    end
                end
                ST_RX_DONE: if (scl_fall) begin
                    d.drive = q.ack;
                    d.state = ST_ACK;
                end
                ST_ACK: if (scl_fall) begin
                    d.drive  = 1'b0;
                    d.bitcnt = '0;
                    if (!q.ack) begin
                        d.state = ST_IDLE;
                    end else if (q.go_tx) begin
                        d.shreg = rd_len;
                        d.drive = ~rd_len[7];
                        d.state = ST_TX;
                    end else begin
                        d.state = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        if (q.bitcnt == 3'd7) d.state  = ST_TX_END;
                        else                  d.bitcnt = q.bitcnt + 3'd1;
                    end else if (scl_fall) begin
                        d.shreg = {q.shreg[6:0], 1'b0};
                        d.drive = ~q.shreg[6];
                    end
                end
                ST_TX_END: if (scl_fall) begin
                    d.drive = 1'b0;
                    d.state = ST_TX_ACK;
                end
                ST_TX_ACK: if (scl_rise) begin
                    d.state = sda_lvl ? ST_IDLE : ST_TX_NEXT;
                end
                ST_TX_NEXT: if (scl_fall) begin
                    d.shreg  = rd_data;
                    d.drive  = ~rd_data[7];
                    d.ptr    = next_ptr;
                    d.bitcnt = '0;
                    d.state  = ST_TX;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, kind: K_ADDR, bitcnt: '0, shreg: '0, ack: 1'b0,
                   go_tx: 1'b0, ptr: '0, left: '0, drive: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rd_idx   = q.ptr;
    assign sda_pull = q.drive;

    // R6: nothing pulls the data line while the target is idle
    p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> !q.drive);

    // R2: the data line is only ever pulled while the clock line is low
    p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.drive) |-> !scl_lvl);

    // R10: the pointer never leaves the bank
    p_ptr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, q.ptr} < (IDX_W + 1)'(NUM_REGS));

    // R4: every accepted data byte consumes one unit of the count
    p_count_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q.left == $past(q.left) - 8'd1));

    // R5: sending starts only after an address acknowledge or a host acknowledge
    p_tx_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_TX && $past(q.state) != ST_TX) |->
        ($past(q.state) == ST_ACK || $past(q.state) == ST_TX_NEXT));

endmodule

// File: rtl/idx_smbus_target.sv
module idx_smbus_target #(
    parameter int         NUM_REGS    = 7,
    parameter logic [7:0] WR_ADDR     = 8'hDC,
    parameter logic [7:0] RD_ADDR     = 8'hDD,
    parameter logic [7:0] MODE_RESET  = 8'h07,
    parameter logic [7:0] MODE_WMASK  = 8'hC7,
    parameter logic [7:0] RDLEN_RESET = 8'h07,
    parameter logic [3:0] VENDOR_CODE = 4'h1,
    parameter logic [7:0] DEV_CODE    = 8'h81
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [3:0] rev_id_i,
    output logic [7:0] mode_o,
    output logic [7:0] out_en_o,
    output logic [7:0] stop_sel_o
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic             scl_rise, scl_fall, scl_lvl, sda_lvl, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data, rd_len;

    ist_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ist_proto_fsm #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .WR_ADDR  (WR_ADDR),
        .RD_ADDR  (RD_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_len    (rd_len),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .sda_pull  (sda_pull_o)
    );

    ist_reg_bank #(
        .NUM_REGS    (NUM_REGS),
        .IDX_W       (IDX_W),
        .MODE_RESET  (MODE_RESET),
        .MODE_WMASK  (MODE_WMASK),
        .RDLEN_RESET (RDLEN_RESET),
        .VENDOR_CODE (VENDOR_CODE),
        .DEV_CODE    (DEV_CODE)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rev_id_i   (rev_id_i),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .rd_len     (rd_len),
        .mode_o     (mode_o),
        .out_en_o   (out_en_o),
        .stop_sel_o (stop_sel_o)
    );

endmodule

// File: tb/idx_smbus_target_tb.sv
module idx_smbus_target_tb;

    localparam int NREG = 7;
    localparam int Q    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic [3:0] rev_id = 4'hA;
    logic sda_pull_o;
    logic sda_line;
    logic [7:0] mode_o, out_en_o, stop_sel_o;

    assign sda_line = host_sda & ~sda_pull_o;

    always #10 clk = ~clk;

    idx_smbus_target u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (host_scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull_o),
        .rev_id_i   (rev_id),
        .mode_o     (mode_o),
        .out_en_o   (out_en_o),
        .stop_sel_o (stop_sel_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cmp_on = 0;
    logic [7:0] exp_regs [NREG];
    logic [7:0] wbuf [8];
    int pend_cnt = 0;
    int pend_idx = 0;
    logic [7:0] pend_val = 8'h00;

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic [7:0] view(input int idx);
        if (idx == 4) return {rev_id, 4'h1};
        if (idx == 5) return 8'h81;
        return exp_regs[idx];
    endfunction

    function automatic void model_write(input int idx, input logic [7:0] v);
        if (idx == 0)                 exp_regs[0] = v & 8'hC7;
        else if (idx != 4 && idx != 5) exp_regs[idx] = v;
    endfunction

    // One system cycle: reference model update and comparison at the negedge
    task automatic step();
        @(negedge clk);
        cyc++;
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) model_write(pend_idx, pend_val);
        end
        if (cmp_on) begin
            check("R12 mode_o", mode_o, exp_regs[0]);
            check("R12 out_en_o", out_en_o, exp_regs[1]);
            check("R12 stop_sel_o", stop_sel_o, exp_regs[2]);
        end
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wait_q(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic start_c();
        host_sda = 1'b1; wait_q(Q);
        host_scl = 1'b1; wait_q(Q);
        host_sda = 1'b0; wait_q(Q);
        host_scl = 1'b0; wait_q(Q);
    endtask

    task automatic stop_c();
        host_sda = 1'b0; wait_q(Q);
        host_scl = 1'b1; wait_q(Q);
        host_sda = 1'b1; wait_q(Q);
    endtask

    task automatic bit_cycle(input logic v, output logic r);
        host_sda = v;    wait_q(Q);
        host_scl = 1'b1; wait_q(Q);
        r = sda_line;    wait_q(Q);
        host_scl = 1'b0; wait_q(Q);
    endtask

    // Sends a byte MSB first; when upd is set the model expects the write
    // three cycles after the SCL rise of the eighth bit
    task automatic send_byte(input logic [7:0] b, input bit upd, input int uidx);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; wait_q(Q);
            host_scl = 1'b1;
            if (i == 0 && upd) begin
                pend_cnt = 3;
                pend_idx = uidx;
                pend_val = b;
            end
            wait_q(2 * Q);
            host_scl = 1'b0; wait_q(Q);
        end
    endtask

    task automatic send_partial(input logic [7:0] b, input int nbits);
        logic r;
        for (int i = 7; i > 7 - nbits; i--) bit_cycle(b[i], r);
    endtask

    task automatic get_ack(output int a);
        logic r;
        bit_cycle(1'b1, r);
        a = (r == 1'b0) ? 1 : 0;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, r);
            b[i] = r;
        end
    endtask

    task automatic wr_txn(input logic [7:0] idx, input int cnt, input int nsend, input string req);
        int a;
        int p;
        start_c();
        send_byte(8'hDC, 0, 0);           get_ack(a); check({req, " addr ack R2"}, a, 1);
        send_byte(idx, 0, 0);             get_ack(a); check({req, " index ack R3"}, a, 1);
        send_byte(8'(cnt), 0, 0);         get_ack(a); check({req, " count ack R3"}, a, 1);
        p = int'(idx) % NREG;
        for (int k = 0; k < nsend; k++) begin
            bit inside_cnt;
            inside_cnt = (k < cnt);
            send_byte(wbuf[k], inside_cnt, p);
            get_ack(a);
            check({req, " data ack"}, a, inside_cnt ? 1 : 0);
            if (!inside_cnt) break;
            p = (p + 1) % NREG;
        end
        stop_c();
        wait_q(2);
    endtask

    task automatic rd_txn(input logic [7:0] idx, input int nread, input string req);
        int a;
        int p;
        logic r;
        logic [7:0] b;
        start_c();
        send_byte(8'hDC, 0, 0); get_ack(a); check({req, " wr addr ack R2"}, a, 1);
        send_byte(idx, 0, 0);   get_ack(a); check({req, " index ack R5"}, a, 1);
        start_c();
        send_byte(8'hDD, 0, 0); get_ack(a); check({req, " rd addr ack R2"}, a, 1);
        recv_byte(b);
        check({req, " length byte R7"}, b, exp_regs[6]);
        bit_cycle((nread == 0) ? 1'b1 : 1'b0, r);
        p = int'(idx) % NREG;
        for (int k = 0; k < nread; k++) begin
            recv_byte(b);
            check({req, " read data"}, b, view(p));
            bit_cycle((k == nread - 1) ? 1'b1 : 1'b0, r);
            p = (p + 1) % NREG;
        end
        wait_q(2);
        check({req, " released after nack R6"}, sda_pull_o, 0);
        stop_c();
        wait_q(2);
    endtask

    initial begin
        int a;
        exp_regs[0] = 8'h07; exp_regs[1] = 8'hFF; exp_regs[2] = 8'h00; exp_regs[3] = 8'h00;
        exp_regs[4] = 8'h00; exp_regs[5] = 8'h00; exp_regs[6] = 8'h07;
        wait_q(5);
        rst_n = 1'b1;
        wait_q(2);
        // R1 reset state
        check("R1 mode_o", mode_o, 8'h07);
        check("R1 out_en_o", out_en_o, 8'hFF);
        check("R1 stop_sel_o", stop_sel_o, 8'h00);
        check("R1 sda_pull_o", sda_pull_o, 0);
        cmp_on = 1;

        // R7 R8 R5: full read of the reset bank, length byte 7
        rd_txn(8'd0, 7, "R5 reset read");

        // R3: two-byte write into registers 1 and 2
        wbuf[0] = 8'h5A; wbuf[1] = 8'h3C;
        wr_txn(8'd1, 2, 2, "R3 write");
        check("R3 out_en_o", out_en_o, 8'h5A);
        check("R3 stop_sel_o", stop_sel_o, 8'h3C);

        // R9: reserved mode bits stay zero
        wbuf[0] = 8'hFF;
        wr_txn(8'd0, 1, 1, "R9 write");
        check("R9 mode_o", mode_o, 8'hC7);

        // R8: writes to identification acknowledged, ignored
        wbuf[0] = 8'h00; wbuf[1] = 8'h00;
        wr_txn(8'd4, 2, 2, "R8 write");
        rev_id = 4'h5;
        wait_q(4);
        rd_txn(8'd4, 2, "R8 read");

        // R7 R10: shorter length register, read wraps past register 6
        wbuf[0] = 8'h03;
        wr_txn(8'd6, 1, 1, "R7 write");
        rd_txn(8'd5, 3, "R10 read wrap");

        // R10: write wraps from register 6 to 0 and 1; index 9 selects register 2
        wbuf[0] = 8'h02; wbuf[1] = 8'h81; wbuf[2] = 8'h0F;
        wr_txn(8'd6, 3, 3, "R10 write wrap");
        check("R10 mode_o", mode_o, 8'h81);
        check("R10 out_en_o", out_en_o, 8'h0F);
        wbuf[0] = 8'h66;
        wr_txn(8'd9, 1, 1, "R10 index modulo");
        check("R10 stop_sel_o", stop_sel_o, 8'h66);

        // R2: foreign address gets no acknowledge; following byte ignored
        start_c();
        send_byte(8'hA0, 0, 0); get_ack(a); check("R2 foreign addr nack", a, 0);
        send_byte(8'hDC, 0, 0); get_ack(a); check("R2 ignored after foreign", a, 0);
        stop_c();
        wait_q(2);

        // R4: byte past the count not acknowledged, not written
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        wr_txn(8'd3, 1, 2, "R4 overrun");
        rd_txn(8'd3, 2, "R4 read");

        // R11: stop in the middle of a data byte
        start_c();
        send_byte(8'hDC, 0, 0); get_ack(a);
        send_byte(8'd1, 0, 0);  get_ack(a);
        send_byte(8'd1, 0, 0);  get_ack(a);
        send_partial(8'h00, 4);
        stop_c();
        wait_q(4);
        check("R11 stop abort out_en_o", out_en_o, 8'h0F);

        // R11: start in the middle of a byte begins a fresh address phase
        start_c();
        send_byte(8'hDC, 0, 0); get_ack(a);
        send_byte(8'd2, 0, 0);  get_ack(a);
        send_byte(8'd1, 0, 0);  get_ack(a);
        send_partial(8'h00, 3);
        wbuf[0] = 8'h77;
        wr_txn(8'd3, 1, 1, "R11 restart");
        check("R11 start abort stop_sel_o", stop_sel_o, 8'h66);
        rd_txn(8'd2, 2, "R11 read");

        // R6: length zero read ends after the length byte
        wbuf[0] = 8'h00;
        wr_txn(8'd6, 1, 1, "R6 length zero");
        rd_txn(8'd0, 0, "R6 nack first");

        cmp_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule